// File: doc/BRIEF.md
# Pulse-swallow programmable frequency divider

This block divides a fast input clock by a programmable ratio of the form 8·N+A. It works like a dual-modulus prescaler. A prescaler phase counter divides by 9 while a swallow counter still holds a non-zero count, and by 8 after that. A main counter counts prescaler periods until N of them have passed, and that ends one division cycle. Only the input clock drives the block, so every count below is in input cycles.

The 14-bit ratio word needs no load strobe. The block samples it only at the edge that ends a division cycle, and at reset. An out-of-range main count is clamped so that the divider always keeps running. At the start of each division cycle the block raises a one-cycle boundary strobe for a downstream phase comparator. At the same time it starts an output pulse that lasts 8 input cycles. An enable input can hold that pulse low without disturbing the count.

Top module: `psw_div`

## Requirements
- R1: The ratio word is split into a swallow count A, taken from bits 2..0, and a main count N, taken from bits 13..3. Consecutive rising cycles of `bound_o` are 8·N+A input cycles apart.
- R2: Within a division cycle, the first A prescaler periods each last 9 input cycles and all later periods last 8.
- R3: The main count in use is the largest of N, A and 2. When N < A the ratio becomes 8·A+A, and when N < 2 (with A < 2) it becomes 16+A.
- R4: The block samples `ratio_i` only at the clock edge that ends a division cycle. A change made in the middle of a cycle first affects the following cycle.
- R5: `pulse_o` goes high in the same cycle as `bound_o` and stays high for exactly 8 input cycles.
- R6: While `oe_i` is low, `pulse_o` is 0. The counting and `bound_o` are unaffected.
- R7: A synchronous active-high reset restarts a division cycle that uses the ratio word present at the reset edge. `bound_o` and `pulse_o` are high in the cycle after each reset edge. The all-ones word, which is the default of undriven inputs, gives a ratio of 16383.
- R8: `bound_o` is high for a single input cycle at each cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock being divided |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | 14 | Ratio word: main count in bits 13..3, swallow count in bits 2..0 |
| oe_i | input | 1 | Output enable for `pulse_o` |
| pulse_o | output | 1 | Divided output pulse, 8 input cycles wide |
| bound_o | output | 1 | One-cycle strobe at the start of each division cycle |

## Verification
A cycle ends on a clock edge. `bound_o` and the ungated pulse come from registers loaded at that edge, so both rise in the clock period that follows it, and the next boundary comes ratio cycles later. `oe_i` gates `pulse_o` without delay, in the same period. The bench samples every output on the falling clock edge and changes inputs 1 ns after that edge. Each interval is therefore measured between falling-edge samples of `bound_o` and compared with the ratio word that was present at the edge that opened the cycle. The pulse width is measured from the `bound_o` sample up to the first sample where the pulse is low.

// File: rtl/psw_div_pkg.sv
package psw_div_pkg;

   localparam int DEF_WORD_W  = 14;
   localparam int DEF_A_W     = 3;
   localparam int DEF_N_FLOOR = 2;

   // main count actually used: never below the swallow count nor the floor
   function automatic int eff_main(input int n, input int a, input int floor_v);
      int r;
      r = n;
      if (a > r)       r = a;
      if (floor_v > r) r = floor_v;
      return r;
   endfunction

endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
   parameter int A_W = 3
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic swallow_i,
   output logic pend_o
);
   localparam int M    = 1 << A_W;
   localparam int PC_W = A_W + 1;
   localparam logic [PC_W-1:0] LAST_BASE = PC_W'(M - 1);
   localparam logic [PC_W-1:0] LAST_SWAL = PC_W'(M);

   logic [PC_W-1:0] pc_q;

   always_comb pend_o = (pc_q == (swallow_i ? LAST_SWAL : LAST_BASE));

   always_ff @(posedge clk_i) begin
      if (rst_i || pend_o) pc_q <= '0;
      else                 pc_q <= pc_q + PC_W'(1);
   end
endmodule

// File: rtl/psw_cycle_ctl.sv
module psw_cycle_ctl #(
   parameter int WORD_W  = 14,
   parameter int A_W     = 3,
   parameter int N_FLOOR = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WORD_W-1:0] ratio_i,
   input  logic              pend_i,
   output logic              swallow_o,
   output logic              reload_o
);
   localparam int N_W = WORD_W - A_W;

   logic [A_W-1:0] a_new, ac_q;
   logic [N_W-1:0] n_new, n_q, nc_q;

   always_comb begin
      a_new = ratio_i[A_W-1:0];
      n_new = N_W'(psw_div_pkg::eff_main(int'(ratio_i[WORD_W-1:A_W]),
                                         int'(a_new), N_FLOOR));
   end

   always_comb begin
      reload_o  = pend_i && (nc_q == (n_q - N_W'(1)));
      swallow_o = (ac_q != '0);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || reload_o) begin
         n_q  <= n_new;
         nc_q <= '0;
         ac_q <= a_new;
      end else if (pend_i) begin
         nc_q <= nc_q + N_W'(1);
         if (ac_q != '0) ac_q <= ac_q - A_W'(1);
      end
   end
endmodule

// File: rtl/psw_shaper.sv
module psw_shaper #(
   parameter int PULSE_W = 8
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic reload_i,
   input  logic oe_i,
   output logic pulse_o,
   output logic bound_o
);
   logic bound_q;
   logic pulse_q;

   always_ff @(posedge clk_i) bound_q <= rst_i | reload_i;

   generate
      if (PULSE_W == 1) begin : g_single
         always_comb pulse_q = bound_q;
      end else begin : g_count
         localparam int CW = $clog2(PULSE_W);
         logic [CW-1:0] wcnt_q;
         always_ff @(posedge clk_i) begin
            if (rst_i || reload_i) begin
               wcnt_q  <= CW'(PULSE_W - 1);
               pulse_q <= 1'b1;
            end else if (wcnt_q != '0) begin
               wcnt_q  <= wcnt_q - CW'(1);
               pulse_q <= 1'b1;
            end else begin
               pulse_q <= 1'b0;
            end
         end
      end
   endgenerate

   assign pulse_o = pulse_q & oe_i;
   assign bound_o = bound_q;
endmodule

// File: rtl/psw_div.sv
module psw_div #(
   parameter int WORD_W  = psw_div_pkg::DEF_WORD_W,
   parameter int A_W     = psw_div_pkg::DEF_A_W,
   parameter int N_FLOOR = psw_div_pkg::DEF_N_FLOOR,
   parameter int PULSE_W = 1 << A_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WORD_W-1:0] ratio_i,
   input  logic              oe_i,
   output logic              pulse_o,
   output logic              bound_o
);
   localparam int M   = 1 << A_W;
   localparam int N_W = WORD_W - A_W;

   generate
      if (A_W < 1 || A_W > 8) begin : g_bad_aw
         $error("psw_div: A_W out of range");
      end
      if (N_W < 2) begin : g_bad_nw
         $error("psw_div: WORD_W too small for main count");
      end
      if (N_FLOOR < 1 || N_FLOOR >= (1 << N_W)) begin : g_bad_floor
         $error("psw_div: N_FLOOR out of range");
      end
      if (PULSE_W < 1 || PULSE_W >= N_FLOOR * M) begin : g_bad_pw
         $error("psw_div: PULSE_W must be shorter than the minimum ratio");
      end
   endgenerate

   logic pre_end;
   logic swallow;
   logic reload;

   psw_prescaler #(.A_W(A_W)) u_pre (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .swallow_i(swallow),
      .pend_o   (pre_end)
   );

   psw_cycle_ctl #(.WORD_W(WORD_W), .A_W(A_W), .N_FLOOR(N_FLOOR)) u_ctl (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ratio_i  (ratio_i),
      .pend_i   (pre_end),
      .swallow_o(swallow),
      .reload_o (reload)
   );

   psw_shaper #(.PULSE_W(PULSE_W)) u_shp (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .reload_i(reload),
      .oe_i    (oe_i),
      .pulse_o (pulse_o),
      .bound_o (bound_o)
   );
endmodule

// File: rtl/psw_div_chk.sv
module psw_div_chk #(
   parameter int A_W     = 3,
   parameter int N_FLOOR = 2,
   parameter int PULSE_W = 8
) (
   input logic clk_i,
   input logic rst_i,
   input logic oe_i,
   input logic pulse_o,
   input logic bound_o,
   input logic pre_end,
   input logic swallow
);
   localparam int M   = 1 << A_W;
   localparam int SAT = 1 << 24;

   int   since_q;
   int   psc_q;
   int   age;
   logic seen_q;

   always_comb age = bound_o ? 0 : since_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         since_q <= 0;
         psc_q   <= 0;
         seen_q  <= 1'b0;
      end else begin
         since_q <= (age < SAT) ? age + 1 : age;
         psc_q   <= pre_end ? 0 : psc_q + 1;
         if (bound_o) seen_q <= 1'b1;
      end
   end

   // R2
   presc_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pre_end |-> (psc_q == (swallow ? M : M - 1)));

   // R5
   pulse_shape_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      oe_i |-> (pulse_o == (age < PULSE_W)));

   // R6
   oe_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !oe_i |-> !pulse_o);

   // R8
   bound_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      bound_o |=> !bound_o);

   // R3
   min_ratio_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (bound_o && seen_q) |-> (since_q >= N_FLOOR * M));
endmodule

bind psw_div psw_div_chk #(.A_W(A_W), .N_FLOOR(N_FLOOR), .PULSE_W(PULSE_W)) u_psw_div_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .oe_i   (oe_i),
   .pulse_o(pulse_o),
   .bound_o(bound_o),
   .pre_end(pre_end),
   .swallow(swallow)
);

// File: tb/psw_div_bench.sv
`timescale 1ns/1ps
module psw_div_bench;
   logic        clk = 1'b0;
   logic        rst_i;
   logic [13:0] ratio_i;
   logic        oe_i;
   logic        pulse_o;
   logic        bound_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   psw_div u_psw_div (
      .clk_i  (clk),
      .rst_i  (rst_i),
      .ratio_i(ratio_i),
      .oe_i   (oe_i),
      .pulse_o(pulse_o),
      .bound_o(bound_o)
   );

   function automatic int exp_ratio(input logic [13:0] w);
      int n, a, ne;
      n  = int'(w[13:3]);
      a  = int'(w[2:0]);
      ne = n;
      if (a > ne) ne = a;
      if (2 > ne) ne = 2;
      return 8 * ne + a;
   endfunction

   function automatic bit is_clamped(input logic [13:0] w);
      return (int'(w[13:3]) < int'(w[2:0])) || (int'(w[13:3]) < 2);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: samples on the falling edge
   int          cnt = 0;
   logic [13:0] start_word = '0;
   bit          have_start = 1'b0;
   bit          from_rst = 1'b0;
   bit          prev_bound = 1'b0;
   bit          prev_rst = 1'b1;
   int          run = 0;
   bit          run_valid = 1'b0;

   always @(negedge clk) begin
      if (!done) begin
         if (bound_o === 1'b1) begin
            if (have_start && !rst_i && !prev_rst)
               chk(cnt == exp_ratio(start_word),
                   $sformatf("R1 R2 R4%s%s interval", is_clamped(start_word) ? " R3" : "",
                             from_rst ? " R7" : ""),
                   cnt, exp_ratio(start_word));
            cnt        = 1;
            start_word = ratio_i;
            have_start = 1'b1;
            from_rst   = rst_i;
         end else begin
            cnt++;
         end

         if (bound_o === 1'b1 && !rst_i && !prev_rst)
            chk(!prev_bound, "R8 bound width", int'(prev_bound), 0);

         if (!oe_i) begin
            chk(pulse_o === 1'b0, "R6 pulse gated", int'(pulse_o), 0);
            run       = 0;
            run_valid = 1'b0;
         end else if (bound_o === 1'b1) begin
            chk(pulse_o === 1'b1, "R5 pulse start", int'(pulse_o), 1);
            run       = 1;
            run_valid = 1'b1;
         end else if (pulse_o === 1'b1) begin
            run++;
         end else begin
            if (run_valid) chk(run == 8, "R5 pulse width", run, 8);
            run       = 0;
            run_valid = 1'b0;
         end

         prev_bound = (bound_o === 1'b1);
         prev_rst   = rst_i;
      end
   end

   task automatic wait_bound();
      do @(negedge clk); while (bound_o !== 1'b1);
   endtask

   task automatic apply(input int n, input int a);
      wait_bound();
      #1 ratio_i = 14'((n << 3) | a);
      wait_bound();
      wait_bound();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1 (run did not complete)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : drive
      void'($urandom(32'd1977));
      rst_i   = 1'b1;
      oe_i    = 1'b1;
      ratio_i = 14'((2 << 3) | 0);
      repeat (3) @(negedge clk);
      chk(bound_o === 1'b1 && pulse_o === 1'b1, "R7 reset state",
          int'({bound_o, pulse_o}), 3);
      #1 rst_i = 1'b0;

      // directed corner cases
      apply(2, 0);     // 16, minimum ratio
      apply(2, 2);     // 18, N equals A
      apply(0, 5);     // N below A and zero: clamp (R3)
      apply(3, 7);     // N below A (R3)
      apply(7, 7);     // N equals A, every period swallows
      apply(1, 0);     // N below floor (R3)
      apply(100, 3);

      // output disabled while counting continues (R6)
      #1 oe_i = 1'b0;
      apply(5, 4);
      apply(12, 1);
      wait_bound();
      #1 oe_i = 1'b1;

      // constrained random ratios
      for (int i = 0; i < 8; i++) begin
         apply(int'($urandom_range(0, 300)), int'($urandom_range(0, 7)));
      end

      // reset with the all-ones default word (R7)
      wait_bound();
      #1 ratio_i = '1;
      rst_i = 1'b1;
      repeat (2) @(negedge clk);
      chk(bound_o === 1'b1 && pulse_o === 1'b1, "R7 reset state",
          int'({bound_o, pulse_o}), 3);
      #1 rst_i = 1'b0;
      wait_bound();
      #1 ratio_i = 14'((3 << 3) | 1);
      wait_bound();
      wait_bound();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule